// File: doc/BRIEF.md
# Parallel NOR Flash Command Sequencer

This block is the device side of a parallel NOR flash that obeys the multi-cycle unlock command protocol. A host issues bus write cycles (address plus data byte) and bus read requests. The sequencer counts and validates the unlock cycles and latches the command it selects. It then runs a program, sector erase or chip erase against a small internal byte array, and a down-counting busy timer sets the length of each operation.

While an operation is running, reads return a status byte whose toggle bits show that the part is busy. The status byte is also returned for the sector of a suspended erase. A sector erase can be paused so that other sectors can be programmed, and then restarted. Autoselect returns identification bytes. Unlock-bypass mode shortens a program to two cycles. The array holds `2**AW` bytes split into sectors of `2**SECT_AW` bytes. It comes out of reset fully erased (every byte 0xFF).

Top module: `nor_cmd_seq`

## Requirements
- R1: A command starts only with a write of 0xAA to address UNLK_A0 (default 0x55), followed by a write of 0x55 to UNLK_A1 (default 0xAA). Any other first write leaves the block in read-array mode. A wrong second write also returns it to read-array mode, and the cycle count restarts.
- R2: The third write must go to UNLK_A0. Its data selects the command: 0xA0 program, 0x90 autoselect, 0x80 erase, 0x20 enter unlock bypass. Any other byte or address returns the block to read-array mode.
- R3: After the program command, the next write stores (old byte AND written byte) at its address. The block then stays busy for PROG_CYC cycles, and any write during that time is ignored.
- R4: After 0x80, a second 0xAA/0x55 unlock pair is needed before the erase byte is taken. Reads between those writes return array data.
- R5: An erase byte of 0x10 starts a chip erase only when written to UNLK_A0; at any other address the block returns to read-array mode. A chip erase sets every byte to 0xFF after 2**CHIP_EXP cycles, and all writes during it are ignored.
- R6: An erase byte of 0x30 erases the sector given by addr[AW-1:SECT_AW] of that write. After SECT_CYC cycles every byte of that sector is 0xFF, and other sectors are unchanged.
- R7: While busy, a read returns a status byte. Bit 6 is the DQ6 toggle and bit 2 is the DQ2 toggle; all other bits are 0. Both toggles are cleared when an operation starts. DQ6 inverts after every busy status read. DQ2 inverts after status reads only during an erase, never during a program.
- R8: In autoselect mode, a read at offset 0x00 returns MFR_ID (default 0x01) and a read at 0x01 returns DEV_ID (default 0x7E). Every other offset reads 0x00. Any write returns the block to read-array mode.
- R9: Writing 0xB0 during a busy sector erase suspends it. Reads of the suspended sector then return status with DQ2 toggling and DQ6 held. Reads of other sectors return array data. A write of 0xB0 in any other state has no effect.
- R10: While an erase is suspended, writing 0x30 at any address resumes it. The block is busy again for a full SECT_CYC cycles, with both toggles cleared, and then the sector is erased.
- R11: While an erase is suspended, a program aimed at the suspended sector is ignored. A program aimed at any other sector takes effect at once, with no busy phase.
- R12: In unlock bypass, a single write of 0xA0 arms a program, and the next write programs as in R3. A write of 0x90 followed by a write of 0x00 leaves bypass. Any other write in bypass is ignored.
- R13: Read data is registered: rdata holds the result of a read one cycle after rd_en. After reset, rdata is 0x00 and every array byte reads 0xFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Bus write cycle strobe |
| rd_en | input | 1 | Bus read request |
| addr | input | AW | Byte address for reads and writes |
| wdata | input | 8 | Write data / command byte |
| rdata | output | 8 | Registered read result |

## Verification
Program is tried on an erased byte and then again on an already programmed byte. The second attempt tells a true AND-merge apart from a plain overwrite. Each erase flavour is run with programmed bytes both inside and outside the target range, which separates sector erase from chip erase and shows whether the sector decode uses the right address bits. Unlock sequences are given with a wrong first byte, a wrong second byte and a wrong chip-erase address, each followed by what would be a valid continuation, so that an over-permissive decoder leaves a visible mark in the array. Back-to-back status reads during program, erase and suspend separate the DQ6 and DQ2 toggle rules for each case.

// File: rtl/nor_seq_pkg.sv
package nor_seq_pkg;
   timeunit 1ns;
   timeprecision 100ps;

   typedef enum logic [3:0] {
      S_IDLE, S_UNL1, S_UNL2, S_AUTOSEL, S_PROG,
      S_EU0, S_EU1, S_ECMD, S_BPROG, S_BCHIP, S_BSECT, S_BYPX
   } nor_st_e;

   localparam logic [7:0] CMD_UNL_A   = 8'hAA;
   localparam logic [7:0] CMD_UNL_B   = 8'h55;
   localparam logic [7:0] CMD_ERASE   = 8'h80;
   localparam logic [7:0] CMD_AUTO    = 8'h90;
   localparam logic [7:0] CMD_PROG    = 8'hA0;
   localparam logic [7:0] CMD_BYP     = 8'h20;
   localparam logic [7:0] CMD_CHIP    = 8'h10;
   localparam logic [7:0] CMD_SECT    = 8'h30;
   localparam logic [7:0] CMD_SUSP    = 8'hB0;
   localparam logic [7:0] CMD_BYP_RST = 8'h00;

   function automatic logic st_is_busy(nor_st_e s);
      return (s == S_BPROG) || (s == S_BCHIP) || (s == S_BSECT);
   endfunction
endpackage

// File: rtl/nor_busy_timer.sv
module nor_busy_timer #(
   parameter int CW = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          start,
   input  logic [CW-1:0] load,
   input  logic          run,
   output logic          done
);
   timeunit 1ns;
   timeprecision 100ps;

   logic [CW-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cnt <= '0;
      else if (start)
         cnt <= load;
      else if (run && (cnt != '0))
         cnt <= cnt - 1'b1;
   end

   assign done = run && (cnt == CW'(1));
endmodule

// File: rtl/nor_cell_array.sv
module nor_cell_array #(
   parameter int AW      = 8,
   parameter int SECT_AW = 6
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               prog_en,
   input  logic [AW-1:0]      prog_addr,
   input  logic [7:0]         prog_data,
   input  logic               ers_en,
   input  logic               ers_all,
   input  logic [AW-SECT_AW-1:0] ers_sect,
   input  logic [AW-1:0]      rd_addr,
   output logic [7:0]         rd_byte
);
   timeunit 1ns;
   timeprecision 100ps;

   localparam int DEPTH = 1 << AW;
   localparam int SW    = AW - SECT_AW;

   logic [7:0]       cells [DEPTH];
   logic [DEPTH-1:0] ers_hit;

   for (genvar g = 0; g < DEPTH; g++) begin : g_hit
      assign ers_hit[g] = ers_all || (SW'(g >> SECT_AW) == ers_sect);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < DEPTH; i++) cells[i] <= 8'hFF;
      end else if (ers_en) begin
         for (int i = 0; i < DEPTH; i++)
            if (ers_hit[i]) cells[i] <= 8'hFF;
      end else if (prog_en) begin
         cells[prog_addr] <= cells[prog_addr] & prog_data;
      end
   end

   assign rd_byte = cells[rd_addr];
endmodule

// File: rtl/nor_cmd_fsm.sv
module nor_cmd_fsm
   import nor_seq_pkg::*;
#(
   parameter int AW       = 8,
   parameter int SECT_AW  = 6,
   parameter int CW       = 8,
   parameter logic [AW-1:0] UNLK_A0 = 'h55,
   parameter logic [AW-1:0] UNLK_A1 = 'hAA,
   parameter int PROG_CYC = 12,
   parameter int SECT_CYC = 40,
   parameter int CHIP_CYC = 128
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  wr_en,
   input  logic [AW-1:0]         addr,
   input  logic [7:0]            wdata,
   input  logic                  tmr_done,
   output nor_st_e               st,
   output logic                  susp,
   output logic                  bypass,
   output logic [AW-SECT_AW-1:0] act_sect,
   output logic                  prog_en,
   output logic                  ers_en,
   output logic                  ers_all,
   output logic                  tmr_start,
   output logic [CW-1:0]         tmr_load,
   output logic                  tmr_run
);
   timeunit 1ns;
   timeprecision 100ps;

   localparam int SW = AW - SECT_AW;

   nor_st_e       st_n;
   logic          susp_n, byp_n;
   logic [SW-1:0] sect_n, wr_sect;

   assign wr_sect = addr[AW-1:SECT_AW];
   assign tmr_run = st_is_busy(st);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st       <= S_IDLE;
         susp     <= 1'b0;
         bypass   <= 1'b0;
         act_sect <= '0;
      end else begin
         st       <= st_n;
         susp     <= susp_n;
         bypass   <= byp_n;
         act_sect <= sect_n;
      end
   end

   always_comb begin
      st_n      = st;
      susp_n    = susp;
      byp_n     = bypass;
      sect_n    = act_sect;
      prog_en   = 1'b0;
      ers_en    = 1'b0;
      ers_all   = 1'b0;
      tmr_start = 1'b0;
      tmr_load  = '0;
      case (st)
         S_IDLE: if (wr_en) begin
            if (bypass) begin
               if (wdata == CMD_PROG)      st_n = S_PROG;
               else if (wdata == CMD_AUTO) st_n = S_BYPX;
            end else if (susp && (wdata == CMD_SECT)) begin
               susp_n    = 1'b0;
               st_n      = S_BSECT;
               tmr_start = 1'b1;
               tmr_load  = CW'(SECT_CYC);
            end else if ((addr == UNLK_A0) && (wdata == CMD_UNL_A)) begin
               st_n = S_UNL1;
            end
         end
         S_UNL1: if (wr_en)
            st_n = ((addr == UNLK_A1) && (wdata == CMD_UNL_B)) ? S_UNL2 : S_IDLE;
         S_UNL2: if (wr_en) begin
            st_n = S_IDLE;
            if (addr == UNLK_A0) begin
               case (wdata)
                  CMD_PROG:  st_n = S_PROG;
                  CMD_AUTO:  st_n = S_AUTOSEL;
                  CMD_ERASE: if (!susp) st_n = S_EU0;
                  CMD_BYP:   byp_n = 1'b1;
                  default:   st_n = S_IDLE;
               endcase
            end
         end
         S_AUTOSEL: if (wr_en) st_n = S_IDLE;
         S_PROG: if (wr_en) begin
            st_n = S_IDLE;
            if (!(susp && (wr_sect == act_sect))) begin
               prog_en = 1'b1;
               if (!susp) begin
                  st_n      = S_BPROG;
                  tmr_start = 1'b1;
                  tmr_load  = CW'(PROG_CYC);
               end
            end
         end
         S_EU0: if (wr_en)
            st_n = ((addr == UNLK_A0) && (wdata == CMD_UNL_A)) ? S_EU1 : S_IDLE;
         S_EU1: if (wr_en)
            st_n = ((addr == UNLK_A1) && (wdata == CMD_UNL_B)) ? S_ECMD : S_IDLE;
         S_ECMD: if (wr_en) begin
            st_n = S_IDLE;
            if ((wdata == CMD_CHIP) && (addr == UNLK_A0)) begin
               st_n      = S_BCHIP;
               tmr_start = 1'b1;
               tmr_load  = CW'(CHIP_CYC);
            end else if (wdata == CMD_SECT) begin
               st_n      = S_BSECT;
               sect_n    = wr_sect;
               tmr_start = 1'b1;
               tmr_load  = CW'(SECT_CYC);
            end
         end
         S_BPROG: if (tmr_done) st_n = S_IDLE;
         S_BCHIP: if (tmr_done) begin
            ers_en  = 1'b1;
            ers_all = 1'b1;
            st_n    = S_IDLE;
         end
         S_BSECT: if (tmr_done) begin
            ers_en = 1'b1;
            st_n   = S_IDLE;
         end else if (wr_en && (wdata == CMD_SUSP)) begin
            susp_n = 1'b1;
            st_n   = S_IDLE;
         end
         S_BYPX: if (wr_en) begin
            st_n = S_IDLE;
            if (wdata == CMD_BYP_RST) byp_n = 1'b0;
         end
         default: st_n = S_IDLE;
      endcase
   end
endmodule

// File: rtl/nor_cmd_seq.sv
module nor_cmd_seq
   import nor_seq_pkg::*;
#(
   parameter int AW       = 8,
   parameter int SECT_AW  = 6,
   parameter logic [AW-1:0] UNLK_A0 = 'h55,
   parameter logic [AW-1:0] UNLK_A1 = 'hAA,
   parameter logic [7:0] MFR_ID = 8'h01,
   parameter logic [7:0] DEV_ID = 8'h7E,
   parameter int PROG_CYC = 12,
   parameter int SECT_CYC = 40,
   parameter int CHIP_EXP = 7
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          wr_en,
   input  logic          rd_en,
   input  logic [AW-1:0] addr,
   input  logic [7:0]    wdata,
   output logic [7:0]    rdata
);
   timeunit 1ns;
   timeprecision 100ps;

   localparam int SW       = AW - SECT_AW;
   localparam int CHIP_CYC = 1 << CHIP_EXP;
   localparam int TMAX     = (CHIP_CYC > SECT_CYC) ?
                             ((CHIP_CYC > PROG_CYC) ? CHIP_CYC : PROG_CYC) :
                             ((SECT_CYC > PROG_CYC) ? SECT_CYC : PROG_CYC);
   localparam int CW       = $clog2(TMAX + 1);

   if (SECT_AW < 1 || SECT_AW >= AW) begin : g_bad_sect
      $error("nor_cmd_seq: SECT_AW must lie in 1..AW-1");
   end
   if (PROG_CYC < 2 || SECT_CYC < 2 || CHIP_EXP < 1 || CHIP_EXP > 30) begin : g_bad_time
      $error("nor_cmd_seq: operation lengths must be at least 2 cycles");
   end
   if (UNLK_A0 == UNLK_A1) begin : g_bad_unlk
      $error("nor_cmd_seq: unlock addresses must differ");
   end

   nor_st_e       st;
   logic          susp, bypass;
   logic [SW-1:0] act_sect;
   logic          prog_en, ers_en, ers_all;
   logic          tmr_start, tmr_run, tmr_done;
   logic [CW-1:0] tmr_load;
   logic [7:0]    arr_byte, rd_next;
   logic          t6, t2;
   logic          stat_busy, ers_busy, sect_hit;

   nor_cmd_fsm #(
      .AW(AW), .SECT_AW(SECT_AW), .CW(CW),
      .UNLK_A0(UNLK_A0), .UNLK_A1(UNLK_A1),
      .PROG_CYC(PROG_CYC), .SECT_CYC(SECT_CYC), .CHIP_CYC(CHIP_CYC)
   ) u_fsm (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
      .tmr_done(tmr_done), .st(st), .susp(susp), .bypass(bypass),
      .act_sect(act_sect), .prog_en(prog_en), .ers_en(ers_en),
      .ers_all(ers_all), .tmr_start(tmr_start), .tmr_load(tmr_load),
      .tmr_run(tmr_run)
   );

   nor_busy_timer #(.CW(CW)) u_tmr (
      .clk(clk), .rst_n(rst_n), .start(tmr_start), .load(tmr_load),
      .run(tmr_run), .done(tmr_done)
   );

   nor_cell_array #(.AW(AW), .SECT_AW(SECT_AW)) u_arr (
      .clk(clk), .rst_n(rst_n), .prog_en(prog_en), .prog_addr(addr),
      .prog_data(wdata), .ers_en(ers_en), .ers_all(ers_all),
      .ers_sect(act_sect), .rd_addr(addr), .rd_byte(arr_byte)
   );

   assign stat_busy = st_is_busy(st);
   assign ers_busy  = (st == S_BCHIP) || (st == S_BSECT);
   assign sect_hit  = susp && (addr[AW-1:SECT_AW] == act_sect);

   always_comb begin
      if (stat_busy || sect_hit)
         rd_next = {1'b0, t6, 3'b000, t2, 2'b00};
      else if (st == S_AUTOSEL)
         rd_next = (addr == AW'(0)) ? MFR_ID :
                   (addr == AW'(1)) ? DEV_ID : 8'h00;
      else
         rd_next = arr_byte;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rdata <= 8'h00;
         t6    <= 1'b0;
         t2    <= 1'b0;
      end else begin
         if (tmr_start) begin
            t6 <= 1'b0;
            t2 <= 1'b0;
         end else if (rd_en && stat_busy) begin
            t6 <= ~t6;
            if (ers_busy) t2 <= ~t2;
         end else if (rd_en && sect_hit) begin
            t2 <= ~t2;
         end
         if (rd_en) rdata <= rd_next;
      end
   end
endmodule

// File: rtl/nor_seq_chk.sv
module nor_seq_chk
   import nor_seq_pkg::*;
#(
   parameter int AW      = 8,
   parameter int SECT_AW = 6,
   parameter logic [AW-1:0] UNLK_A0 = 'h55,
   parameter logic [AW-1:0] UNLK_A1 = 'hAA
) (
   input logic                  clk,
   input logic                  rst_n,
   input logic                  wr_en,
   input logic                  rd_en,
   input logic [AW-1:0]         addr,
   input logic [7:0]            wdata,
   input nor_st_e               st,
   input logic                  susp,
   input logic                  bypass,
   input logic [AW-SECT_AW-1:0] act_sect,
   input logic                  t6,
   input logic                  t2,
   input logic                  tmr_done
);
   timeunit 1ns;
   timeprecision 100ps;

   logic busy_c, shit_c;
   assign busy_c = (st == S_BPROG) || (st == S_BCHIP) || (st == S_BSECT);
   assign shit_c = susp && (addr[AW-1:SECT_AW] == act_sect);

   AST_STRAY_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
      (st == S_IDLE && !bypass && !susp && wr_en && !(addr == UNLK_A0 && wdata == 8'hAA))
      |=> (st == S_IDLE)); // R1
   AST_BAD_SECOND: assert property (@(posedge clk) disable iff (!rst_n)
      (st == S_UNL1 && wr_en && !(addr == UNLK_A1 && wdata == 8'h55))
      |=> (st == S_IDLE)); // R1
   AST_DQ6_FLIPS: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_c && rd_en) |=> (t6 != $past(t6))); // R7
   AST_PROG_DQ2_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      (st == S_BPROG && rd_en) |=> $stable(t2)); // R7
   AST_CHIP_DEAF: assert property (@(posedge clk) disable iff (!rst_n)
      (st == S_BCHIP && !tmr_done) |=> (st == S_BCHIP)); // R5
   AST_SUSP_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(susp) |-> ($past(st) == S_BSECT)); // R9
   AST_SUSP_DQ6_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      (st == S_IDLE && shit_c && rd_en && !wr_en) |=> $stable(t6)); // R9
   AST_RESUME: assert property (@(posedge clk) disable iff (!rst_n)
      (st == S_IDLE && susp && !bypass && wr_en && wdata == 8'h30)
      |=> (st == S_BSECT && !susp)); // R10
   AST_BYP_LEAVE: assert property (@(posedge clk) disable iff (!rst_n)
      (st == S_BYPX && wr_en && wdata == 8'h00) |=> (!bypass && st == S_IDLE)); // R12
endmodule

bind nor_cmd_seq nor_seq_chk #(
   .AW(AW), .SECT_AW(SECT_AW), .UNLK_A0(UNLK_A0), .UNLK_A1(UNLK_A1)
) u_chk (
   .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
   .wdata(wdata), .st(st), .susp(susp), .bypass(bypass),
   .act_sect(act_sect), .t6(t6), .t2(t2), .tmr_done(tmr_done)
);

// File: tb/sim_nor_cmd_seq.sv
module sim_nor_cmd_seq;
   timeunit 1ns;
   timeprecision 100ps;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       wr_en = 1'b0;
   logic       rd_en = 1'b0;
   logic [7:0] addr  = 8'h00;
   logic [7:0] wdata = 8'h00;
   logic [7:0] rdata;
   int         n_chk = 0;
   int         n_fail = 0;

   always #2.5 clk = ~clk;

   nor_cmd_seq u0 (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en),
      .addr(addr), .wdata(wdata), .rdata(rdata)
   );

   task automatic chk(input string tag, input logic [7:0] got, input logic [7:0] exp);
      n_chk++;
      if (got !== exp) begin
         n_fail++;
         $display("FAIL %s: actual=%02h expected=%02h", tag, got, exp);
      end
   endtask

   task automatic wr(input logic [7:0] a, input logic [7:0] d);
      @(negedge clk);
      wr_en = 1'b1; addr = a; wdata = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic rd(input logic [7:0] a, output logic [7:0] d);
      @(negedge clk);
      rd_en = 1'b1; addr = a;
      @(negedge clk);
      rd_en = 1'b0;
      d = rdata;
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic unlock(input logic [7:0] cmd);
      wr(8'h55, 8'hAA);
      wr(8'hAA, 8'h55);
      wr(8'h55, cmd);
   endtask

   task automatic prog(input logic [7:0] a, input logic [7:0] d);
      unlock(8'hA0);
      wr(a, d);
      idle(16);
   endtask

   task automatic t_reset();
      logic [7:0] v;
      chk("R13 rdata after reset", rdata, 8'h00);
      rd(8'h00, v); chk("R13 erased at reset 0x00", v, 8'hFF);
      rd(8'h9A, v); chk("R13 erased at reset 0x9A", v, 8'hFF);
   endtask

   task automatic t_program();
      logic [7:0] v;
      unlock(8'hA0);
      wr(8'h10, 8'h3C);
      rd(8'h10, v); chk("R7 prog status read 1", v, 8'h00);
      rd(8'h10, v); chk("R7 prog status read 2 (DQ6 only)", v, 8'h40);
      wr(8'h10, 8'h00);                       // must be ignored while busy
      idle(16);
      rd(8'h10, v); chk("R3 program result", v, 8'h3C);
      prog(8'h10, 8'hF5);
      rd(8'h10, v); chk("R3 program AND merge", v, 8'h34);
   endtask

   task automatic t_bad_unlock();
      logic [7:0] v;
      wr(8'h55, 8'hA0);
      wr(8'h20, 8'h00);
      rd(8'h20, v); chk("R1 bare command ignored", v, 8'hFF);
      wr(8'h55, 8'hAA);
      wr(8'hAA, 8'h12);
      wr(8'h55, 8'hA0);
      wr(8'h20, 8'h00);
      rd(8'h20, v); chk("R1 wrong second cycle aborts", v, 8'hFF);
      wr(8'h55, 8'hAB);
      wr(8'hAA, 8'h55);
      wr(8'h55, 8'hA0);
      wr(8'h21, 8'h00);
      rd(8'h21, v); chk("R1 wrong first cycle ignored", v, 8'hFF);
      wr(8'h55, 8'hAA);
      wr(8'hAA, 8'h55);
      wr(8'h56, 8'hA0);
      wr(8'h22, 8'h00);
      rd(8'h22, v); chk("R2 command at wrong address rejected", v, 8'hFF);
   endtask

   task automatic t_autosel();
      logic [7:0] v;
      unlock(8'h90);
      rd(8'h00, v); chk("R8 manufacturer id", v, 8'h01);
      rd(8'h01, v); chk("R8 device id", v, 8'h7E);
      rd(8'h05, v); chk("R8 other offset", v, 8'h00);
      wr(8'h00, 8'hF0);
      rd(8'h10, v); chk("R8 write leaves autoselect", v, 8'h34);
   endtask

   task automatic t_idle_suspend();
      logic [7:0] v;
      wr(8'h10, 8'hB0);
      rd(8'h10, v); chk("R9 idle 0xB0 no effect", v, 8'h34);
      prog(8'h11, 8'h77);
      rd(8'h11, v); chk("R9 commands work after idle 0xB0", v, 8'h77);
   endtask

   task automatic t_sector_erase();
      logic [7:0] v;
      prog(8'h45, 8'h00);
      prog(8'h81, 8'h00);
      unlock(8'h80);
      rd(8'h45, v); chk("R4 array read during second unlock", v, 8'h00);
      wr(8'h55, 8'hAA);
      wr(8'hAA, 8'h55);
      wr(8'h50, 8'h30);
      rd(8'h45, v); chk("R7 erase status read 1", v, 8'h00);
      rd(8'h45, v); chk("R7 erase status read 2 (DQ6+DQ2)", v, 8'h44);
      idle(50);
      rd(8'h45, v); chk("R6 target sector erased", v, 8'hFF);
      rd(8'h81, v); chk("R6 other sector kept", v, 8'h00);
      rd(8'h10, v); chk("R6 sector 0 kept", v, 8'h34);
   endtask

   task automatic t_suspend();
      logic [7:0] v;
      prog(8'h60, 8'h00);
      prog(8'h90, 8'h00);
      unlock(8'h80);
      wr(8'h55, 8'hAA);
      wr(8'hAA, 8'h55);
      wr(8'h60, 8'h30);
      wr(8'h00, 8'hB0);
      rd(8'h60, v); chk("R9 suspended sector status 1", v, 8'h00);
      rd(8'h60, v); chk("R9 suspended sector DQ2 only", v, 8'h04);
      rd(8'h90, v); chk("R9 other sector array data", v, 8'h00);
      unlock(8'hA0);
      wr(8'h61, 8'h00);
      rd(8'h90, v); chk("R11 ignored program leaves no busy", v, 8'h00);
      unlock(8'hA0);
      wr(8'h91, 8'h0F);
      rd(8'h91, v); chk("R11 program in suspend immediate", v, 8'h0F);
      wr(8'h00, 8'hB0);
      rd(8'h90, v); chk("R9 0xB0 while suspended no effect", v, 8'h00);
      wr(8'h00, 8'h30);
      rd(8'h90, v); chk("R10 resumed status read 1", v, 8'h00);
      rd(8'h90, v); chk("R10 resumed status read 2", v, 8'h44);
      idle(50);
      rd(8'h60, v); chk("R10 sector erased after resume", v, 8'hFF);
      rd(8'h61, v); chk("R11 erasing-sector byte", v, 8'hFF);
      rd(8'h90, v); chk("R10 other sector kept 0x90", v, 8'h00);
      rd(8'h91, v); chk("R11 suspend program kept", v, 8'h0F);
   endtask

   task automatic t_chip_erase();
      logic [7:0] v;
      unlock(8'h80);
      wr(8'h55, 8'hAA);
      wr(8'hAA, 8'h55);
      wr(8'h20, 8'h10);
      rd(8'h10, v); chk("R5 chip erase wrong address rejected", v, 8'h34);
      unlock(8'h80);
      wr(8'h55, 8'hAA);
      wr(8'hAA, 8'h55);
      wr(8'h55, 8'h10);
      rd(8'h10, v); chk("R7 chip status read 1", v, 8'h00);
      rd(8'h10, v); chk("R7 chip status read 2", v, 8'h44);
      wr(8'h55, 8'hAA);                       // ignored during chip erase
      idle(140);
      wr(8'hAA, 8'h55);
      wr(8'h55, 8'hA0);
      wr(8'h30, 8'h00);
      rd(8'h30, v); chk("R5 writes ignored during chip erase", v, 8'hFF);
      rd(8'h10, v); chk("R5 chip erased 0x10", v, 8'hFF);
      rd(8'h90, v); chk("R5 chip erased 0x90", v, 8'hFF);
   endtask

   task automatic t_bypass();
      logic [7:0] v;
      unlock(8'h20);
      wr(8'h00, 8'hA0);
      wr(8'h22, 8'h5A);
      idle(16);
      rd(8'h22, v); chk("R12 bypass program", v, 8'h5A);
      wr(8'h23, 8'h77);
      rd(8'h23, v); chk("R12 stray bypass write ignored", v, 8'hFF);
      wr(8'h00, 8'h90);
      wr(8'h00, 8'h00);
      wr(8'h55, 8'hA0);
      wr(8'h24, 8'h00);
      rd(8'h24, v); chk("R12 bypass exited", v, 8'hFF);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog: R13 run hung, actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      idle(3);
      rst_n = 1'b1;
      idle(2);
      t_reset();
      t_program();
      t_bad_unlock();
      t_autosel();
      t_idle_suspend();
      t_sector_erase();
      t_suspend();
      t_chip_erase();
      t_bypass();
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule